// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of bytes into an HDLC line bit stream. A frame opens with a 0x7E flag. Its data bytes follow, least significant bit first, with a ZERO stuffed after every run of five ONEs. The frame ends with a 16-bit check word that is supplied from outside, followed by a closing flag. Bytes come from a source that presents a byte with a valid bit and an end-of-frame tag. The framer pulses `src_take` in the cycle it consumes a byte.

Between frames the line is filled according to a two-bit mode. The line can carry continuous flags, continuous ONEs, or go-ahead units. Flag fill and idle fill give way as soon as a byte is waiting. Go-ahead fill does not give way until the mode is changed. A fourth mode code sends bytes raw, with no protocol processing.

An abort command cuts the current frame short with seven ONEs. A one-bit-period end-of-packet strobe marks the last bit of every closing flag and every abort. All line activity advances only on cycles where `bit_en` is high, so the block can serve a gated timeslot.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `tx_bit` is ONE, `tx_eop` is low and `src_take` is low.
- R2: `tx_bit` and `tx_eop` change only at clock edges where `bit_en` was high. Each such edge emits exactly one line bit.
- R3: Fill mode 00 sends continuous flags 0x7E, least significant bit first (bits 0,1,1,1,1,1,1,0), whole flags only.
- R4: Fill mode 01 sends continuous ONEs. In modes 00 and 01, a byte waiting at a fill-unit boundary starts a frame with one opening flag.
- R5: Fill mode 10 sends repeated 9-bit go-ahead units (seven ONEs, then two ZEROs). It consumes no byte even when one is waiting, until the mode is changed.
- R6: Data and check bits go out least significant bit first. After any five consecutive ONEs among them, a ZERO is inserted.
- R7: After a byte tagged end-of-frame, the 16-bit `check_word` captured with that byte is sent, then a closing flag. The next frame waits for the next fill-unit boundary.
- R8: `tx_eop` is high for exactly one bit period, during the last bit of a closing flag or of an abort.
- R9: `abort_req` high on a `bit_en` cycle while a frame is in progress (opening flag, data or check word) starts seven ONEs, after which fill resumes. In fill, transparent, closing-flag or abort states it has no effect.
- R10: If a new byte is needed mid-frame and none is valid, the frame is aborted exactly as in R9.
- R11: Fill mode 11 sends each waiting byte raw, least significant bit first, with no flags, no stuffing and no check word. The end-of-frame tag is ignored, and the line sends ONEs when no byte waits.
- R12: `src_take` is high only on a `bit_en` cycle with `src_valid` high, exactly once per byte consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advance the line by one bit this cycle |
| fill_mode | input | 2 | 00 flags, 01 ONEs, 10 go-ahead, 11 transparent |
| abort_req | input | 1 | Abort the frame in progress |
| src_valid | input | 1 | A byte is offered |
| src_data | input | DW | Offered byte |
| src_last | input | 1 | Offered byte ends the frame |
| check_word | input | CW | Check word, captured with the last byte |
| src_take | output | 1 | The offered byte is consumed this cycle |
| tx_bit | output | 1 | Serial line bit |
| tx_eop | output | 1 | End-of-packet strobe |

## Verification
The assertions hold on every cycle for a few properties. The line and strobe stay frozen without `bit_en`. A byte is never consumed without a valid offer, nor during go-ahead fill. The strobe never lasts past one bit. An abort emits only ONEs, and data and check fields never carry six ONEs in a row. The exact bit patterns of each fill mode can only be shown by the bench's scenarios. The same holds for the placement of flags and check word around stuffed data, the moment an abort takes effect, the underrun path and raw transparent output. There, a behavioural model predicts each line bit and each byte fetch.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int ABORT_ONES = 7,
  parameter int RUN_MAX = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic [1:0]    fill_mode,
  input  logic          abort_req,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  input  logic          src_last,
  input  logic [CW-1:0] check_word,
  output logic          src_take,
  output logic          tx_bit,
  output logic          tx_eop
);

  localparam int SW0  = (CW > DW) ? CW : DW;
  localparam int SW   = (SW0 < 9) ? 9 : SW0;
  localparam int CMAX = (SW > ABORT_ONES) ? SW : ABORT_ONES;
  localparam int CNTW = $clog2(CMAX + 1);
  localparam int RUNW = $clog2(RUN_MAX + 1);

  localparam logic [2:0] ST_FILL  = 3'd0;
  localparam logic [2:0] ST_OPEN  = 3'd1;
  localparam logic [2:0] ST_DATA  = 3'd2;
  localparam logic [2:0] ST_FCS   = 3'd3;
  localparam logic [2:0] ST_CLOSE = 3'd4;
  localparam logic [2:0] ST_ABORT = 3'd5;
  localparam logic [2:0] ST_RAW   = 3'd6;

  localparam logic [1:0] M_FLAG = 2'b00;
  localparam logic [1:0] M_GA   = 2'b10;
  localparam logic [1:0] M_RAW  = 2'b11;

  localparam logic [SW-1:0] FLAG_TAIL = SW'(8'h3F);
  localparam logic [SW-1:0] GA_TAIL   = SW'(9'h03F);

  logic [2:0]      state, n_state;
  logic [SW-1:0]   sh, n_sh;
  logic [CNTW-1:0] cnt, n_cnt;
  logic [RUNW-1:0] run, n_run;
  logic [CW-1:0]   chk, n_chk;
  logic            last_seen, n_last;
  logic            n_bit, n_eop, take;
  logic            go_abort, go_fill, go_bnd;

  wire mid     = (cnt != '0);
  wire framing = (state == ST_OPEN) || (state == ST_DATA) || (state == ST_FCS);
  wire at_run  = (run == RUNW'(RUN_MAX));

  assign src_take = take;

  always_comb begin
    n_state = state;
    n_sh    = sh;
    n_cnt   = cnt;
    n_run   = run;
    n_chk   = chk;
    n_last  = last_seen;
    n_bit   = tx_bit;
    n_eop   = tx_eop;
    take    = 1'b0;
    go_abort = 1'b0;
    go_fill  = 1'b0;
    go_bnd   = 1'b0;

    if (bit_en) begin
      n_eop = 1'b0;
      if (framing && abort_req) begin
        go_abort = 1'b1;
      end else begin
        case (state)
          ST_OPEN: begin
            if (mid) begin
              n_bit = sh[0];
              n_sh  = sh >> 1;
              n_cnt = cnt - 1'b1;
            end else begin
              go_bnd = 1'b1;
            end
          end
          ST_DATA, ST_FCS: begin
            if (at_run) begin
              n_bit = 1'b0;
              n_run = '0;
            end else if (mid) begin
              n_bit = sh[0];
              n_sh  = sh >> 1;
              n_cnt = cnt - 1'b1;
              n_run = sh[0] ? RUNW'(run + 1'b1) : '0;
            end else if (state == ST_DATA) begin
              go_bnd = 1'b1;
            end else begin
              n_state = ST_CLOSE;
              n_bit   = 1'b0;
              n_sh    = FLAG_TAIL;
              n_cnt   = CNTW'(7);
              n_run   = '0;
            end
          end
          default: begin
            if (mid) begin
              n_bit = sh[0];
              n_sh  = sh >> 1;
              n_cnt = cnt - 1'b1;
              n_eop = ((state == ST_CLOSE) || (state == ST_ABORT)) && (cnt == CNTW'(1));
            end else begin
              go_fill = 1'b1;
            end
          end
        endcase
      end

      if (go_bnd) begin
        n_state = ST_DATA;
        if (last_seen) begin
          n_state = ST_FCS;
          n_bit   = chk[0];
          n_sh    = SW'(chk >> 1);
          n_cnt   = CNTW'(CW - 1);
          n_run   = chk[0] ? RUNW'(run + 1'b1) : '0;
        end else if (src_valid) begin
          take   = 1'b1;
          n_bit  = src_data[0];
          n_sh   = SW'(src_data >> 1);
          n_cnt  = CNTW'(DW - 1);
          n_run  = src_data[0] ? RUNW'(run + 1'b1) : '0;
          n_last = src_last;
          if (src_last) n_chk = check_word;
        end else begin
          go_abort = 1'b1;
        end
      end

      if (go_abort) begin
        n_state = ST_ABORT;
        n_bit   = 1'b1;
        n_sh    = '1;
        n_cnt   = CNTW'(ABORT_ONES - 1);
        n_run   = '0;
        n_eop   = (ABORT_ONES == 1);
      end

      if (go_fill) begin
        n_run = '0;
        case (fill_mode)
          M_RAW: begin
            if (src_valid) begin
              take    = 1'b1;
              n_state = ST_RAW;
              n_bit   = src_data[0];
              n_sh    = SW'(src_data >> 1);
              n_cnt   = CNTW'(DW - 1);
            end else begin
              n_state = ST_FILL;
              n_bit   = 1'b1;
              n_cnt   = '0;
            end
          end
          M_GA: begin
            n_state = ST_FILL;
            n_bit   = 1'b1;
            n_sh    = GA_TAIL;
            n_cnt   = CNTW'(8);
          end
          default: begin
            if (src_valid) begin
              n_state = ST_OPEN;
              n_bit   = 1'b0;
              n_sh    = FLAG_TAIL;
              n_cnt   = CNTW'(7);
              n_last  = 1'b0;
            end else if (fill_mode == M_FLAG) begin
              n_state = ST_FILL;
              n_bit   = 1'b0;
              n_sh    = FLAG_TAIL;
              n_cnt   = CNTW'(7);
            end else begin
              n_state = ST_FILL;
              n_bit   = 1'b1;
              n_cnt   = '0;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      sh        <= '0;
      cnt       <= '0;
      run       <= '0;
      chk       <= '0;
      last_seen <= 1'b0;
      tx_bit    <= 1'b1;
      tx_eop    <= 1'b0;
    end else begin
      state     <= n_state;
      sh        <= n_sh;
      cnt       <= n_cnt;
      run       <= n_run;
      chk       <= n_chk;
      last_seen <= n_last;
      tx_bit    <= n_bit;
      tx_eop    <= n_eop;
    end
  end

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic [1:0] fill_mode,
  input logic       src_valid,
  input logic       src_take,
  input logic       tx_bit,
  input logic       tx_eop,
  input logic [2:0] state
);

  logic       en_q;
  logic [3:0] ones_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ones_run <= '0;
    end else begin
      en_q <= bit_en;
      if (en_q)
        ones_run <= (((state == 3'd2) || (state == 3'd3)) && tx_bit) ? ones_run + 4'd1 : 4'd0;
    end
  end

  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(tx_eop))); // R2
  AST_TAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |-> (bit_en && src_valid)); // R12
  AST_EOP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eop && bit_en) |=> !tx_eop); // R8
  AST_STUFF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ones_run <= 4'd5); // R6
  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5) |-> tx_bit); // R9
  AST_GA_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill_mode == 2'b10) && (state == 3'd0)) |-> !src_take); // R5

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fill_mode(fill_mode),
  .src_valid(src_valid), .src_take(src_take), .tx_bit(tx_bit),
  .tx_eop(tx_eop), .state(state)
);

// File: tb/hdlc_tx_framer_bench.sv
`timescale 1ns/1ps
module hdlc_tx_framer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic [1:0]  fill_mode = 2'b01;
  logic        abort_req = 1'b0;
  logic        src_valid = 1'b0;
  logic [7:0]  src_data = '0;
  logic        src_last = 1'b0;
  logic [15:0] check_word = '0;
  logic        src_take, tx_bit, tx_eop;

  always #5 clk = ~clk;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fill_mode(fill_mode),
    .abort_req(abort_req), .src_valid(src_valid), .src_data(src_data),
    .src_last(src_last), .check_word(check_word), .src_take(src_take),
    .tx_bit(tx_bit), .tx_eop(tx_eop)
  );

  typedef struct packed { logic b; logic e; logic ab; logic tk; } mbit_t;
  typedef struct packed { logic [7:0] d; logic l; } sbyte_t;

  mbit_t  mq[$];
  sbyte_t sq[$];

  int n_chk = 0, n_bad = 0;
  int cyc = 0, en_div = 1, eop_seen = 0, ones = 0;
  string cur_req = "R1";
  logic [1:0]  mode_r = 2'b01;
  logic        abort_r = 1'b0;
  logic [15:0] fcs_r = '0;
  logic exp_bit = 1'b1, exp_eop = 1'b0, prev_ab = 1'b0, take_exp = 1'b0;
  logic pend_pop = 1'b0, prev_en = 1'b0, run_on = 1'b0, en_now = 1'b0;

  function void check_bit(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, cyc);
    end
  endfunction

  function void check_int(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function void push_b(logic b, logic e, logic ab, logic tk);
    mbit_t m;
    m.b = b; m.e = e; m.ab = ab; m.tk = tk;
    mq.push_back(m);
  endfunction

  function void push_flag(logic ab);
    for (int k = 0; k < 8; k++) push_b(((8'h7E >> k) & 1) != 0, 1'b0, ab, 1'b0);
  endfunction

  function void push_data(logic b, logic tk);
    push_b(b, 1'b0, 1'b1, tk);
    ones = b ? ones + 1 : 0;
    if (ones == 5) begin
      push_b(1'b0, 1'b0, 1'b1, 1'b0);
      ones = 0;
    end
  endfunction

  function void push_abort();
    for (int k = 0; k < 7; k++) push_b(1'b1, k == 6, 1'b0, 1'b0);
  endfunction

  function void build_frame();
    bit got_last;
    got_last = 0;
    push_flag(1'b1);
    ones = 0;
    foreach (sq[i]) begin
      for (int k = 0; k < 8; k++) push_data(sq[i].d[k], k == 0);
      if (sq[i].l) begin
        got_last = 1;
        break;
      end
    end
    if (got_last) begin
      for (int k = 0; k < 16; k++) push_data(fcs_r[k], 1'b0);
      for (int k = 0; k < 8; k++) push_b(((8'h7E >> k) & 1) != 0, k == 7, 1'b0, 1'b0);
    end else begin
      push_abort();
    end
  endfunction

  function void model_step(logic [1:0] mode, logic abrt);
    mbit_t m;
    if (abrt && prev_ab) begin
      mq.delete();
      push_abort();
    end else if (mq.size() == 0) begin
      if (mode == 2'b11) begin
        if (sq.size() > 0)
          for (int k = 0; k < 8; k++) push_b(sq[0].d[k], 1'b0, 1'b0, k == 0);
        else
          push_b(1'b1, 1'b0, 1'b0, 1'b0);
      end else if (mode == 2'b10) begin
        for (int k = 0; k < 9; k++) push_b(k < 7, 1'b0, 1'b0, 1'b0);
      end else if (sq.size() > 0) begin
        build_frame();
      end else if (mode == 2'b00) begin
        push_flag(1'b0);
      end else begin
        push_b(1'b1, 1'b0, 1'b0, 1'b0);
      end
    end
    m = mq.pop_front();
    exp_bit  = m.b;
    exp_eop  = m.e;
    prev_ab  = m.ab;
    take_exp = m.tk;
  endfunction

  always @(negedge clk) begin
    if (run_on) begin
      check_bit(cur_req, "tx_bit", tx_bit, exp_bit);
      check_bit(cur_req, "tx_eop", tx_eop, exp_eop);
      if (tx_eop && prev_en) eop_seen++;
      if (pend_pop && sq.size() > 0) void'(sq.pop_front());
      pend_pop = 1'b0;
      cyc++;
      en_now     = (cyc % en_div) == 0;
      bit_en     = en_now;
      fill_mode  = mode_r;
      abort_req  = abort_r;
      check_word = fcs_r;
      src_valid  = sq.size() > 0;
      src_data   = (sq.size() > 0) ? sq[0].d : 8'h00;
      src_last   = (sq.size() > 0) ? sq[0].l : 1'b0;
      #1;
      take_exp = 1'b0;
      if (en_now) model_step(mode_r, abort_r);
      check_bit("R12", "src_take", src_take, take_exp);
      pend_pop = take_exp;
      prev_en  = en_now;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic push(logic [7:0] d, logic l);
    sbyte_t s;
    s.d = d; s.l = l;
    sq.push_back(s);
  endtask

  task automatic pulse_abort();
    @(posedge clk);
    abort_r = 1'b1;
    @(posedge clk);
    abort_r = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1", "tx_bit after reset", tx_bit, 1'b1);
    check_bit("R1", "tx_eop after reset", tx_eop, 1'b0);
    check_bit("R1", "src_take after reset", src_take, 1'b0);
    @(posedge clk);
    run_on = 1'b1;

    cur_req = "R3"; en_div = 3; mode_r = 2'b00;  // R2 gated enable, R3 flag fill
    wait_cyc(90);

    cur_req = "R6"; en_div = 1; mode_r = 2'b01;  // R4 idle then frame, R6 stuffing, R7 check word
    wait_cyc(20);
    e0 = eop_seen;
    fcs_r = 16'hFFFF;
    push(8'hFF, 0); push(8'h1F, 0); push(8'hF8, 1);
    wait_cyc(120);
    check_int("R7", "bytes left after frame", sq.size(), 0);
    check_int("R8", "eop pulses for one frame", eop_seen - e0, 1);

    cur_req = "R4"; en_div = 2; mode_r = 2'b00;
    e0 = eop_seen;
    fcs_r = 16'h1234;
    push(8'h7E, 0); push(8'h3C, 1);
    wait_cyc(200);
    check_int("R4", "bytes left after flag-fill frame", sq.size(), 0);
    check_int("R8", "eop pulses after flag-fill frame", eop_seen - e0, 1);

    cur_req = "R5"; en_div = 1; mode_r = 2'b10;
    wait_cyc(20);
    fcs_r = 16'hBEEF;
    push(8'hA5, 0); push(8'h5A, 1);
    wait_cyc(100);
    check_int("R5", "bytes kept during go-ahead", sq.size(), 2);
    mode_r = 2'b00;
    wait_cyc(150);
    check_int("R5", "bytes sent after leaving go-ahead", sq.size(), 0);

    cur_req = "R9"; mode_r = 2'b01;
    wait_cyc(20);
    fcs_r = 16'h0F0F;
    push(8'hFF, 0); push(8'hFF, 0); push(8'hFF, 0);
    push(8'hFF, 0); push(8'hFF, 0); push(8'hFF, 1);
    wait_cyc(30);
    e0 = eop_seen;
    pulse_abort();
    sq.delete();
    wait_cyc(40);
    check_int("R9", "eop pulses for abort", eop_seen - e0, 1);
    e0 = eop_seen;
    pulse_abort();
    wait_cyc(20);
    check_int("R9", "eop pulses for abort in fill", eop_seen - e0, 0);

    cur_req = "R10";
    e0 = eop_seen;
    push(8'h81, 0); push(8'h3F, 0);
    wait_cyc(80);
    check_int("R10", "eop pulses on underrun", eop_seen - e0, 1);
    check_int("R10", "bytes left on underrun", sq.size(), 0);

    cur_req = "R11"; mode_r = 2'b11;
    wait_cyc(20);
    e0 = eop_seen;
    push(8'hFF, 0); push(8'hFF, 1); push(8'h00, 0);
    wait_cyc(60);
    check_int("R11", "bytes left in transparent", sq.size(), 0);
    check_int("R11", "eop pulses in transparent", eop_seen - e0, 0);
    mode_r = 2'b01;
    wait_cyc(20);

    finish_run();
  end

endmodule